// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Parallel Receiver

This block turns a recovered serial bit stream into aligned 10-bit code groups. An upstream recovery stage samples each bit and marks it with a data-valid strobe on the system clock. The block shifts these bits into a sliding window and hunts for the 8B/10B comma in it. When byte synchronization is enabled and a comma shows up at a bit position that is not the current word boundary, the boundary moves at once. The comma then becomes the code group that is delivered next. When synchronization is switched off, the boundary found last is kept, whatever the stream carries.

Each delivered word is marked by a one-cycle valid pulse. Every word also toggles a pair of complementary half-rate byte clock enables, so words land alternately on the rising edge of one enable and then of the other. A loopback select takes the local transmit serial stream as the receiver input in place of the line input. At the nominal 1062.5 Mbaud line rate, words come at 106.25 MHz and each byte clock enable runs at 53.125 MHz.

Top module: `comma_rx`

## Requirements
- R1: While reset is asserted and until the first word is delivered, `word_o` is 0, `word_valid_o` is 0, `comma_o` is 0, `bclk0_en_o` is 0 and `bclk1_en_o` is 1.
- R2: Serial bits are taken in arrival order, and the first bit of a word becomes bit 0 of `word_o`. Out of reset the boundary offset is 0, so the first word is delivered once 10 valid bits have arrived. `word_o` changes only when a word is delivered.
- R3: A clock cycle with `bit_valid` low takes no bit and delivers no word.
- R4: A word is a comma when its bits [6:0] equal 7'b1111100 or 7'b0000011. These are the arrival-order patterns 0011111 and 1100000, so both disparity forms count. `comma_o` is high with a delivered word exactly when that word is a comma.
- R5: With `sync_en` high, a comma whose last bit arrives at any offset ends a word on that bit, and the word delivered is the comma. Later words follow every 10 valid bits from that point.
- R6: With `sync_en` low, the boundary is held: words are delivered every 10 valid bits, and commas at other offsets do not move the boundary.
- R7: A word is presented on `word_o` with a one-cycle `word_valid_o` pulse in the cycle after the clock edge that takes its last bit. `word_o` and `comma_o` hold until the next word.
- R8: `bclk0_en_o` and `bclk1_en_o` are always complementary and toggle exactly when a word is delivered. The 1st, 3rd, 5th… words coincide with a rise of `bclk0_en_o`, and the others with a rise of `bclk1_en_o`.
- R9: With `loopback_en` high the receiver takes `tx_bit`; with it low the receiver takes `line_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe: a serial bit is present this cycle |
| line_bit | input | 1 | Serial bit from the line |
| tx_bit | input | 1 | Serial bit from the local transmitter |
| loopback_en | input | 1 | Select `tx_bit` as the receiver source |
| sync_en | input | 1 | Enable comma realignment |
| word_o | output | 10 | Aligned code group, bit 0 first received |
| word_valid_o | output | 1 | One-cycle pulse per delivered word |
| comma_o | output | 1 | Delivered word is a comma |
| bclk0_en_o | output | 1 | Half-rate byte clock enable, phase 0 |
| bclk1_en_o | output | 1 | Half-rate byte clock enable, phase 1 (complement) |

## Verification
Commas of both disparities are sent after 1 to 9 filler bits, so realignment is tried at every offset. Each case shows whether the boundary jumps to the comma's last bit, rather than to a fixed cadence or to one off. The same comma sent at a misaligned offset with synchronization off shows whether the boundary is really frozen. Streams with idle strobe cycles between bits tell bit counting apart from cycle counting. A stream driven with opposite values on the line and transmit inputs tells which source the loopback select actually picks.

// File: rtl/comma_rx_pkg.sv
package comma_rx_pkg;
    // Comma patterns as stored in word bits [6:0] (bit 0 = earliest bit)
    localparam int COMMA_W = 7;
    localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b1111100; // arrival 0011111
    localparam logic [COMMA_W-1:0] COMMA_POS = 7'b0000011; // arrival 1100000
endpackage

// File: rtl/comma_rx_src_mux.sv
module comma_rx_src_mux (
    input  logic loopback_en,
    input  logic line_bit,
    input  logic tx_bit,
    output logic src_bit
);
    always_comb begin
        src_bit = loopback_en ? tx_bit : line_bit;
    end
endmodule

// File: rtl/comma_rx_detect.sv
module comma_rx_detect
    import comma_rx_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic [WORD_W-1:0] cand,
    output logic              hit
);
    localparam int NPAT = 2;
    logic [NPAT-1:0] match;

    for (genvar p = 0; p < NPAT; p++) begin : g_pat
        localparam logic [COMMA_W-1:0] PAT = (p == 0) ? COMMA_NEG : COMMA_POS;
        assign match[p] = (cand[COMMA_W-1:0] == PAT);
    end

    assign hit = |match;
endmodule

// File: rtl/comma_rx_framer.sv
module comma_rx_framer #(
    parameter int WORD_W = 10,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              sync_en,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              comma_o,
    output logic              phase_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] win;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  seen;
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              comma;
        logic              phase;
    } state_t;

    state_t s_q, s_d;
    logic [WORD_W-1:0] win_sh;
    logic              hit;
    logic              full_now;
    logic              boundary;

    // newest bit enters at the top, so after WORD_W shifts bit 0 is the oldest
    assign win_sh = {bit_in, s_q.win[WORD_W-1:1]};

    comma_rx_detect #(.WORD_W(WORD_W)) u_detect (
        .cand (win_sh),
        .hit  (hit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.valid = 1'b0;
        full_now = (s_q.seen >= LAST);
        boundary = 1'b0;
        if (bit_valid) begin
            s_d.win = win_sh;
            if (s_q.seen < FULL) begin
                s_d.seen = s_q.seen + 1'b1;
            end
            boundary = (s_q.cnt == LAST) || (sync_en && full_now && hit);
            if (boundary) begin
                s_d.cnt   = '0;
                s_d.word  = win_sh;
                s_d.valid = 1'b1;
                s_d.comma = hit;
                s_d.phase = ~s_q.phase;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o  = s_q.word;
    assign valid_o = s_q.valid;
    assign comma_o = s_q.comma;
    assign phase_o = s_q.phase;
endmodule

// File: rtl/comma_rx.sv
module comma_rx #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              line_bit,
    input  logic              tx_bit,
    input  logic              loopback_en,
    input  logic              sync_en,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              comma_o,
    output logic              bclk0_en_o,
    output logic              bclk1_en_o
);
    logic src_bit;
    logic phase;

    comma_rx_src_mux u_mux (
        .loopback_en (loopback_en),
        .line_bit    (line_bit),
        .tx_bit      (tx_bit),
        .src_bit     (src_bit)
    );

    comma_rx_framer #(.WORD_W(WORD_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (src_bit),
        .sync_en   (sync_en),
        .word_o    (word_o),
        .valid_o   (word_valid_o),
        .comma_o   (comma_o),
        .phase_o   (phase)
    );

    assign bclk0_en_o = phase;
    assign bclk1_en_o = ~phase;
endmodule

// File: rtl/comma_rx_chk.sv
module comma_rx_chk
    import comma_rx_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_valid,
    input logic [WORD_W-1:0] word_o,
    input logic              word_valid_o,
    input logic              comma_o,
    input logic              bclk0_en_o,
    input logic              bclk1_en_o
);
    localparam int SPAN_W = $clog2(WORD_W + 2);
    logic [SPAN_W-1:0] span_q;

    // valid bits taken since the last delivered word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
        end else if (word_valid_o) begin
            span_q <= SPAN_W'(bit_valid);
        end else if (bit_valid && span_q <= SPAN_W'(WORD_W)) begin
            span_q <= span_q + 1'b1;
        end
    end

    AST_BCLK_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        bclk0_en_o != bclk1_en_o); // R8
    AST_BCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> !$stable(bclk0_en_o)); // R8
    AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(bclk0_en_o)); // R8
    AST_NO_IDLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_valid) |-> !word_valid_o); // R3
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_o)); // R2
    AST_COMMA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (comma_o == ((word_o[COMMA_W-1:0] == COMMA_NEG) ||
                                      (word_o[COMMA_W-1:0] == COMMA_POS)))); // R4
    AST_MAX_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        span_q <= SPAN_W'(WORD_W)); // R6
endmodule

bind comma_rx comma_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_valid    (bit_valid),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .comma_o      (comma_o),
    .bclk0_en_o   (bclk0_en_o),
    .bclk1_en_o   (bclk1_en_o)
);

// File: tb/tb_comma_rx.sv
module tb_comma_rx;
    logic clk = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic       rst_n, bit_valid, line_bit, tx_bit, loopback_en, sync_en;
    logic [9:0] word_o;
    logic       word_valid_o, comma_o, bclk0_en_o, bclk1_en_o;

    comma_rx dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .line_bit(line_bit),
        .tx_bit(tx_bit), .loopback_en(loopback_en), .sync_en(sync_en),
        .word_o(word_o), .word_valid_o(word_valid_o), .comma_o(comma_o),
        .bclk0_en_o(bclk0_en_o), .bclk1_en_o(bclk1_en_o)
    );

    localparam logic [9:0] K_NEG = 10'h17C; // arrival 0011111010
    localparam logic [9:0] K_POS = 10'h283; // arrival 1100000101
    localparam logic [9:0] DATA  = 10'h2AA;

    int n_tests = 0, n_fail = 0;
    bit stream [0:4095];
    int nbits = 0;
    logic [9:0] rec_w [0:511];
    bit rec_c [0:511];
    bit rec_b0 [0:511];
    int rec_end [0:511];
    int nrec = 0;
    int compl_err = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (bclk0_en_o == bclk1_en_o) compl_err++;
            if (word_valid_o && nrec < 512) begin
                rec_w[nrec]   = word_o;
                rec_c[nrec]   = comma_o;
                rec_b0[nrec]  = bclk0_en_o;
                rec_end[nrec] = nbits;
                nrec++;
            end
        end
    end

    function automatic logic [9:0] pack(input int start);
        logic [9:0] v;
        for (int i = 0; i < 10; i++) v[i] = stream[start + i];
        return v;
    endfunction

    task automatic send_bit(input bit b);
        @(negedge clk);
        bit_valid = 1'b1;
        line_bit  = loopback_en ? ~b : b;
        tx_bit    = loopback_en ? b : ~b;
        @(posedge clk);
        stream[nbits] = b;
        nbits++;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
            line_bit  = $urandom_range(0, 1);
            tx_bit    = $urandom_range(0, 1);
        end
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; bit_valid = 0; line_bit = 0; tx_bit = 0;
        loopback_en = 0; sync_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(word_o == 0 && !word_valid_o && !comma_o, "R1 data/valid/comma", {word_o, word_valid_o, comma_o}, 0);
        chk(!bclk0_en_o && bclk1_en_o, "R1 byte clocks", {bclk0_en_o, bclk1_en_o}, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        idle(1);
        chk(word_o == 0 && nrec == 0, "R2 zero before first word", word_o, 0);
        send_bit(0); send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        idle(1);
        chk(nrec == 1 && rec_end[0] == 10, "R2 first boundary", rec_end[0], 10);
        chk(rec_w[0] == pack(0), "R2 bit order", rec_w[0], pack(0));
        chk(rec_b0[0] == 1'b1, "R8 first word on bclk0", rec_b0[0], 1);
    endtask

    task automatic t_gaps();
        int n0;
        n0 = nrec;
        for (int i = 0; i < 10; i++) begin
            send_bit(DATA[i]);
            idle(2);
        end
        chk(nrec == n0 + 1, "R3 one word over gaps", nrec - n0, 1);
        chk(rec_w[nrec-1] == DATA && rec_end[nrec-1] == nbits, "R3 gap word", rec_w[nrec-1], DATA);
    endtask

    task automatic t_realign(input int k, input bit pos);
        logic [9:0] kc;
        kc = pos ? K_POS : K_NEG;
        sync_en = 1'b1;
        for (int i = 0; i < k; i++) send_bit(i[0]);
        send_word(kc);
        idle(1);
        chk(rec_end[nrec-1] == nbits, "R5 boundary at comma", rec_end[nrec-1], nbits);
        chk(rec_w[nrec-1] == kc && rec_c[nrec-1], "R4 comma word and flag", {rec_c[nrec-1], rec_w[nrec-1]}, {1'b1, kc});
        send_word(DATA);
        idle(1);
        chk(rec_w[nrec-1] == DATA && !rec_c[nrec-1] && rec_end[nrec-1] == nbits,
            "R5 next word aligned", rec_w[nrec-1], DATA);
    endtask

    task automatic t_hold();
        int b0, n0;
        bit hit;
        b0 = nbits; n0 = nrec;
        sync_en = 1'b0;
        send_bit(0); send_bit(1); send_bit(0);
        send_word(K_NEG);
        for (int i = 0; i < 7; i++) send_bit(~i[0]);
        idle(1);
        chk(nrec == n0 + 2, "R6 word count held", nrec - n0, 2);
        hit = 0;
        for (int i = n0; i < nrec; i++) if (rec_end[i] == b0 + 13) hit = 1;
        chk(!hit, "R6 no realign on comma", hit, 0);
        chk(rec_end[nrec-2] == b0 + 10 && rec_w[nrec-2] == pack(b0), "R6 first held word", rec_w[nrec-2], pack(b0));
        chk(rec_end[nrec-1] == b0 + 20 && rec_w[nrec-1] == pack(b0 + 10), "R6 second held word", rec_w[nrec-1], pack(b0 + 10));
        chk(!rec_c[nrec-2] && !rec_c[nrec-1], "R4 no flag for split comma", rec_c[nrec-1], 0);
        sync_en = 1'b1;
    endtask

    task automatic t_loop();
        loopback_en = 1'b1;
        send_bit(1); send_bit(0); send_bit(1);
        send_word(K_POS);
        send_word(DATA);
        idle(1);
        chk(rec_w[nrec-2] == K_POS && rec_c[nrec-2], "R9 loopback comma", rec_w[nrec-2], K_POS);
        chk(rec_w[nrec-1] == DATA && rec_end[nrec-1] == nbits, "R9 loopback data", rec_w[nrec-1], DATA);
        loopback_en = 1'b0;
        send_word(10'h0F3);
        idle(1);
        chk(rec_w[nrec-1] == 10'h0F3, "R9 line source", rec_w[nrec-1], 10'h0F3);
    endtask

    task automatic t_pairing();
        bit alt;
        alt = 1;
        for (int i = 1; i < nrec; i++) if (rec_b0[i] == rec_b0[i-1]) alt = 0;
        chk(alt, "R8 words alternate between byte clocks", alt, 1);
        chk(compl_err == 0, "R8 byte clocks complementary", compl_err, 0);
        chk(rec_b0[0] && !rec_b0[1], "R7 pulse per word pairing", {rec_b0[0], rec_b0[1]}, 2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_gaps();
        for (int k = 1; k <= 9; k++) t_realign(k, k[0]);
        t_hold();
        t_loop();
        t_pairing();
        finish_run();
    end
endmodule